// File: doc/BRIEF.md
# Receive Word Label Filter and Buffer

This block sits behind one serial receive decoder of a 32-bit avionics data word link. Each decoded word is screened by two optional rules before it is kept: its 8-bit label field (word bits 1 to 8) must equal one of sixteen programmed labels, and its two source/destination bits (word bits 9 and 10) must equal two programmed values. Words that pass are stored in a 32-word buffer. Words that fail are dropped without any trace.

A host reads each stored word as two 16-bit halves. A byte-select input picks the half. The buffer advances only after both halves of the head word have been read. The high 16 bits of the host data path can follow one of two bit mappings. Three active-low flags report the fill level: data present, at least half full, and full.

When the label-sequence mode input rises, the host fills the label table with sixteen writes and can then read it back with sixteen reads. Reception is suspended while this mode is active. Configuration arrives on plain inputs. Word bit n (counted from 1) is carried on `rx_word[n-1]`.

Top module: `rx_label_buffer`

## Requirements
- R1: With `lbl_chk_en`=1, a received word is stored only if `rx_word[7:0]` equals one of the 16 table entries, compared bit for bit (entry bit i against word bit i+1). The value 8'h00 matches like any other value, and the comparison does not depend on `unscramble`.
- R2: With `dec_chk_en`=1, a received word is stored only if `rx_word[8]`==`dec_b9` and `rx_word[9]`==`dec_b10`.
- R3: With both checks enabled, a word is stored only when both pass. A rejected word changes no flag and no stored data. With both checks disabled, every received word is stored.
- R4: While `lbl_mode`=1, `rx_valid` is ignored. The host writes (`host_wr`) fill table entries 0,1,2,… in order from `host_wdata`.
- R5: While `lbl_mode`=1, `rd_data` shows {8'h00, entry[addr]}, and each `host_rd` advances to the next entry.
- R6: The buffer holds 32 words. A word accepted while the buffer is full, with no pop in the same cycle, replaces the most recently stored word.
- R7: `dr_n`=0 while one or more words are held. `hf_n`=0 while 16 or more are held. `ff_n`=0 while 32 are held. All three are 1 after reset.
- R8: In normal mode, `rd_data` shows the head word half chosen by `byte_sel`. The head is removed on the `host_rd` that completes the reading of both halves, in either order. Repeated reads of one half do not remove it.
- R9: With `unscramble`=0, half 0 is (MSB to LSB) word bits 13,12,11,10,9,31,30,32,1,2,…,8, and half 1 is word bits 29 down to 14.
- R10: With `unscramble`=1, half 0 is word bits 16 down to 1, and half 1 is word bits 32 down to 17.
- R11: The table address wraps to 0 after entry 15, and it returns to 0 whenever `lbl_mode` is 0.
- R12: An accepted word and a completing read in the same cycle while full both take effect: the head leaves, the new word is appended, and the count stays 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; empties the buffer |
| lbl_mode | input | 1 | Label table sequence mode |
| lbl_chk_en | input | 1 | Enable the label match rule |
| dec_chk_en | input | 1 | Enable the bit 9/10 rule |
| dec_b9 | input | 1 | Required value of word bit 9 |
| dec_b10 | input | 1 | Required value of word bit 10 |
| unscramble | input | 1 | Select the straight bit mapping |
| rx_valid | input | 1 | Decoded word strobe |
| rx_word | input | 32 | Decoded word, bit n at index n-1 |
| host_wr | input | 1 | Label write strobe |
| host_wdata | input | 8 | Label write value |
| host_rd | input | 1 | Read strobe |
| byte_sel | input | 1 | Half select for reads |
| rd_data | output | 16 | Read data |
| dr_n | output | 1 | Data present, active low |
| hf_n | output | 1 | Half full, active low |
| ff_n | output | 1 | Full, active low |

## Verification
The hardest case to reach is the full buffer. There, an overwrite of the newest entry and a same-cycle pop-and-push are each reached only after 32 accepted words with no completing read. The bench fills the buffer under directed stimulus and pushes extra words. It then overlaps a push with the second-half read and drains the buffer against its queue model. Label-rule rejections depend on matching a random label against the table, so half of the random words take their label from the table to exercise both outcomes.

// File: rtl/rx_label_buffer.sv
module rx_label_buffer #(
  parameter int DEPTH  = 32,
  parameter int NLBL   = 16,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lbl_mode,
  input  logic              lbl_chk_en,
  input  logic              dec_chk_en,
  input  logic              dec_b9,
  input  logic              dec_b10,
  input  logic              unscramble,
  input  logic              rx_valid,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  input  logic              host_rd,
  input  logic              byte_sel,
  output logic [15:0]       rd_data,
  output logic              dr_n,
  output logic              hf_n,
  output logic              ff_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int LW = $clog2(NLBL);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [CW-1:0] HALF_CNT = CW'(DEPTH / 2);

  logic [7:0]        lbl_mem [NLBL];
  logic [LW-1:0]     lbl_addr;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rptr, wptr;
  logic [CW-1:0]     count;
  logic              got_lo, got_hi;
  logic              lbl_hit, dec_ok, push, pop, full, rd_ok;
  logic [WORD_W-1:0] head;
  logic [15:0]       half0, half1;

  always_comb begin
    lbl_hit = 1'b0;
    for (int i = 0; i < NLBL; i++)
      if (lbl_mem[i] == rx_word[7:0]) lbl_hit = 1'b1;
  end

  assign dec_ok = (rx_word[8] == dec_b9) && (rx_word[9] == dec_b10);
  assign push   = rx_valid && !lbl_mode && (!lbl_chk_en || lbl_hit) && (!dec_chk_en || dec_ok);
  assign full   = (count == FULL_CNT);
  assign rd_ok  = host_rd && !lbl_mode && (count != '0);
  assign pop    = rd_ok && (byte_sel ? got_lo : got_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lbl_addr <= '0;
    end else if (!lbl_mode) begin
      lbl_addr <= '0;
    end else if (host_wr || host_rd) begin
      lbl_addr <= lbl_addr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (lbl_mode && host_wr) lbl_mem[lbl_addr] <= host_wdata;
  end

  always_ff @(posedge clk) begin
    if (push) mem[(full && !pop) ? wptr - 1'b1 : wptr] <= rx_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr   <= '0;
      wptr   <= '0;
      count  <= '0;
      got_lo <= 1'b0;
      got_hi <= 1'b0;
    end else begin
      if (pop) rptr <= rptr + 1'b1;
      if (push && !(full && !pop)) wptr <= wptr + 1'b1;
      if (push && !full && !pop)      count <= count + 1'b1;
      else if (pop && !push)          count <= count - 1'b1;
      if (pop) begin
        got_lo <= 1'b0;
        got_hi <= 1'b0;
      end else if (rd_ok) begin
        if (byte_sel) got_hi <= 1'b1;
        else          got_lo <= 1'b1;
      end
    end
  end

  assign head = mem[rptr];

  always_comb begin
    if (unscramble) begin
      half0 = head[15:0];
      half1 = head[31:16];
    end else begin
      half0[15:11] = head[12:8];
      half0[10]    = head[30];
      half0[9]     = head[29];
      half0[8]     = head[31];
      for (int b = 0; b < 8; b++) half0[7-b] = head[b];
      half1 = head[28:13];
    end
  end

  always_comb begin
    if (lbl_mode)            rd_data = {8'h00, lbl_mem[lbl_addr]};
    else if (count == '0)    rd_data = '0;
    else                     rd_data = byte_sel ? half1 : half0;
  end

  assign dr_n = (count == '0);
  assign hf_n = !(count >= HALF_CNT);
  assign ff_n = !full;

  p_bound_r6: assert property (@(posedge clk) disable iff (!rst_n) count <= FULL_CNT);

  p_keep_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ff_n && push && !pop) |=> !ff_n);

  p_suspend_r4: assert property (@(posedge clk) disable iff (!rst_n)
    lbl_mode |=> $stable(count));

  p_dec_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && dec_chk_en && (rx_word[8] != dec_b9) && !host_rd) |=> $stable(count));

  p_addr_home_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !lbl_mode |=> (lbl_addr == '0));

  p_one_pop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> (count == $past(count) - 1'b1));

  p_swap_full_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop) |=> full);
endmodule

// File: tb/rx_label_buffer_tb_top.sv
module rx_label_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lbl_mode = 0, lbl_chk_en = 0, dec_chk_en = 0, dec_b9 = 0, dec_b10 = 0, unscramble = 0;
  logic        rx_valid = 0, host_wr = 0, host_rd = 0, byte_sel = 0;
  logic [31:0] rx_word = '0;
  logic [7:0]  host_wdata = '0;
  logic [15:0] rd_data;
  logic        dr_n, hf_n, ff_n;

  int n_tests = 0, n_fail = 0;
  logic [31:0] q[$];
  logic [7:0]  lbls [16];

  always #2 clk = ~clk;

  rx_label_buffer dut_i (
    .clk(clk), .rst_n(rst_n), .lbl_mode(lbl_mode), .lbl_chk_en(lbl_chk_en),
    .dec_chk_en(dec_chk_en), .dec_b9(dec_b9), .dec_b10(dec_b10), .unscramble(unscramble),
    .rx_valid(rx_valid), .rx_word(rx_word), .host_wr(host_wr), .host_wdata(host_wdata),
    .host_rd(host_rd), .byte_sel(byte_sel), .rd_data(rd_data),
    .dr_n(dr_n), .hf_n(hf_n), .ff_n(ff_n));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] f_half(input logic [31:0] w, input bit sel, input bit alt);
    logic [15:0] h;
    if (alt) h = sel ? w[31:16] : w[15:0];
    else if (sel) h = w[28:13];
    else h = {w[12], w[11], w[10], w[9], w[8], w[30], w[29], w[31],
              w[0], w[1], w[2], w[3], w[4], w[5], w[6], w[7]};
    return h;
  endfunction

  function automatic bit f_take(input logic [31:0] w);
    bit hit = 0;
    for (int i = 0; i < 16; i++) if (lbls[i] == w[7:0]) hit = 1;
    return (!lbl_chk_en || hit) && (!dec_chk_en || (w[8] == dec_b9 && w[9] == dec_b10));
  endfunction

  task automatic check_flags(input string tag);
    logic [2:0] exp;
    exp = {q.size() == 0, q.size() < 16, q.size() < 32};
    check({dr_n, hf_n, ff_n} == exp, tag, {dr_n, hf_n, ff_n}, exp);
  endtask

  task automatic send(input logic [31:0] w, input string tag);
    rx_word = w; rx_valid = 1;
    if (!lbl_mode && f_take(w)) begin
      if (q.size() == 32) q[31] = w; else q.push_back(w);
    end
    @(negedge clk); rx_valid = 0;
    check_flags(tag);
  endtask

  task automatic read_word(input bit first, input bit alt, input string tag);
    unscramble = alt;
    for (int k = 0; k < 2; k++) begin
      byte_sel = (k == 0) ? first : !first; host_rd = 1; #1;
      check(rd_data == f_half(q[0], byte_sel, alt), tag, rd_data, f_half(q[0], byte_sel, alt));
      @(negedge clk);
    end
    host_rd = 0; void'(q.pop_front());
    check_flags(tag);
  endtask

  task automatic lbl_write(input logic [7:0] v);
    host_wdata = v; host_wr = 1; @(negedge clk); host_wr = 0;
  endtask

  initial begin
    #(4 * 200000);
    check(0, "watchdog", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1; @(negedge clk);
    check({dr_n, hf_n, ff_n} == 3'b111, "R7 reset flags", {dr_n, hf_n, ff_n}, 3'b111);

    // R4/R5/R11: program table, entry 5 = 8'h00, read back after wrap
    lbl_mode = 1; @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      lbls[i] = (i == 5) ? 8'h00 : 8'(8'h30 + 7 * i);
      lbl_write(lbls[i]);
    end
    send(32'hDEAD_BE31, "R4 rx ignored in label mode");
    for (int i = 0; i < 16; i++) begin
      host_rd = 1; #1;
      check(rd_data == {8'h00, lbls[i]}, "R5 label readback", rd_data, {8'h00, lbls[i]});
      @(negedge clk);
    end
    host_rd = 0;
    // R11: leaving the mode returns the address to entry 0
    lbl_write(8'hA1); lbls[0] = 8'hA1;
    lbl_write(8'hA2); lbls[1] = 8'hA2;
    lbl_mode = 0; @(negedge clk);
    lbl_mode = 1; #1;
    check(rd_data == {8'h00, lbls[0]}, "R11 address reset", rd_data, {8'h00, lbls[0]});
    @(negedge clk); lbl_mode = 0; @(negedge clk);

    // R1: label rule, 8'h00 matches
    lbl_chk_en = 1;
    send(32'h1234_5600, "R1 zero label accepted");
    check(q.size() == 1, "R1 zero label stored", q.size(), 1);
    send(32'h1234_56FF, "R1 unknown label rejected");
    read_word(0, 0, "R9 default mapping");
    // R2/R3
    dec_chk_en = 1; dec_b9 = 1; dec_b10 = 0;
    send(32'h0000_0100 | lbls[3], "R3 both pass");
    send(32'h0000_0200 | lbls[3], "R3 decoder fails");
    send(32'h0000_0155, "R3 label fails");
    read_word(1, 1, "R10 alternate mapping");
    lbl_chk_en = 0;
    send(32'hFFFF_FD00, "R2 bit9/10 pass");
    send(32'hFFFF_FC00, "R2 bit9 fails");
    dec_chk_en = 0;
    read_word(1, 0, "R8 reverse order");

    // R8: repeated same-half read does not pop
    send(32'hCAFE_0001, "R3 no rules");
    send(32'hCAFE_0002, "R3 no rules");
    host_rd = 1; byte_sel = 0; @(negedge clk); @(negedge clk); host_rd = 0;
    check_flags("R8 same half twice");
    byte_sel = 1; #1;
    check(rd_data == f_half(q[0], 1, 0), "R8 head kept", rd_data, f_half(q[0], 1, 0));
    host_rd = 1; @(negedge clk); host_rd = 0; void'(q.pop_front());
    check_flags("R8 pop after second half");
    read_word(0, 1, "R8 drain");

    // R6/R7/R12: fill, overwrite, pop-and-push at full
    for (int i = 0; i < 34; i++) send(32'hB000_0000 + i, "R7 fill flags");
    check(q.size() == 32, "R6 capacity", q.size(), 32);
    byte_sel = 0; host_rd = 1; @(negedge clk);
    byte_sel = 1; rx_word = 32'h5A5A_0F0F; rx_valid = 1; @(negedge clk);
    host_rd = 0; rx_valid = 0; void'(q.pop_front()); q.push_back(32'h5A5A_0F0F);
    check_flags("R12 swap at full");
    while (q.size() > 0) read_word(q.size() % 2, q.size() % 3 == 0, "R6 R12 drain order");

    // random mix
    for (int it = 0; it < 600; it++) begin
      lbl_chk_en = $urandom_range(0, 1); dec_chk_en = $urandom_range(0, 1);
      dec_b9 = $urandom_range(0, 1); dec_b10 = $urandom_range(0, 1);
      if ($urandom_range(0, 2) != 0 || q.size() == 0) begin
        w = $urandom;
        if ($urandom_range(0, 1) != 0) w[7:0] = lbls[$urandom_range(0, 15)];
        send(w, "R1 R2 R3 random push");
      end else read_word($urandom_range(0, 1), $urandom_range(0, 1), "R9 R10 random read");
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule